// File: doc/BRIEF.md
# Far-Return Protection Checker

This block decides whether a far return in protected mode may proceed. It receives the current privilege level, the return code selector with the attributes of the descriptor it names, and, for a return to a less privileged level, the return stack selector with its descriptor attributes. It also receives the stack pointer and stack limit, the code segment limit and the return offset. The checks run in a fixed order. The block reports either success, with a flag for the outer-level path, or the first check that failed, with its fault class and its 16-bit error code.

The block does no memory access and loads no registers. The pipeline around it fetches the selectors and descriptors and does the table-limit comparisons. It then presents one request with `req_valid`, and the verdict appears one cycle later. A selector is 16 bits: bits 15:3 are the index, bit 2 is the table indicator and bits 1:0 are the requested privilege level (RPL). The immediate count is a number of bytes that is added to the stack area.

Top module: `frc_far_ret_check`

## Requirements
- R1: A request with `req_valid` high at a rising clock edge produces `res_valid` high for exactly the following cycle, carrying that request's verdict. With no request, `res_valid` is low the following cycle. Reset clears all outputs to zero.
- R2: Highest priority: if the bytes from `stk_ptr` up to `stk_ptr`+A-1 exceed `stk_lim`, the result is a stack fault (fault code 3) with error code 0. A is 4 bytes for 16-bit size (`op32`=0) and 8 bytes for 32-bit size.
- R3: If the RPL of the code selector is below `cpl`, the result is a general-protection fault (fault code 1) carrying the code selector.
- R4: An RPL equal to `cpl` takes the same-level path. A larger RPL takes the outer path. `res_outer` is 1 only on a successful outer-path return.
- R5: A null code selector (bits 15:2 all zero) gives a general-protection fault with error code 0.
- R6: A code selector outside its table (`cs_in_tbl`=0), or a descriptor that is not code (`cs_is_code`=0), gives a general-protection fault carrying the code selector. The table check comes first.
- R7: The target level is `cpl` on the same-level path and the RPL on the outer path. A non-conforming segment needs DPL equal to the target level. A conforming segment needs DPL no greater than it. A violation gives a general-protection fault carrying the code selector.
- R8: A code segment that is not present gives a not-present fault (fault code 2) carrying the code selector.
- R9: On the outer path, the stack check runs right after the RPL check. Its area is 8 bytes (16-bit) or 16 bytes (32-bit) plus `imm`, and an overflow gives a stack fault with error code 0.
- R10: On the outer path, after the code-segment checks, the stack selector is checked in this order. A null selector gives a general-protection fault with error code 0. Each of these gives a general-protection fault carrying the stack selector: outside its table, RPL not equal to the code RPL, descriptor not a writable data segment, DPL not equal to the code RPL. A segment that is not present then gives a not-present fault carrying the stack selector.
- R11: Last: a `ret_ofs` greater than `cs_lim` gives a general-protection fault with error code 0.
- R12: Fault codes: 0 none, 1 general protection, 2 not present, 3 stack. An error code that carries a selector is the selector with bits 1:0 cleared. On success the error code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| op32 | input | 1 | 1 for 32-bit operand size |
| cpl | input | 2 | Current privilege level |
| imm | input | 16 | Immediate byte count |
| stk_ptr | input | ADDR_W | Current stack pointer |
| stk_lim | input | ADDR_W | Stack segment limit |
| cs_sel | input | 16 | Return code selector |
| cs_in_tbl | input | 1 | Code selector index within its table |
| cs_is_code | input | 1 | Descriptor is a code segment |
| cs_conf | input | 1 | Code segment is conforming |
| cs_dpl | input | 2 | Code descriptor DPL |
| cs_present | input | 1 | Code segment present |
| cs_lim | input | ADDR_W | Code segment limit |
| ret_ofs | input | ADDR_W | Return offset |
| ss_sel | input | 16 | Return stack selector |
| ss_in_tbl | input | 1 | Stack selector index within its table |
| ss_wr_data | input | 1 | Descriptor is a writable data segment |
| ss_dpl | input | 2 | Stack descriptor DPL |
| ss_present | input | 1 | Stack segment present |
| res_valid | output | 1 | Verdict valid |
| res_fault | output | 2 | Fault class |
| res_code | output | 16 | Error code |
| res_outer | output | 1 | Successful outer-level return |

## Verification
On every cycle, the assertions check the one-cycle request-to-verdict timing, that a failed first stack check always wins, and that a low RPL yields a general-protection fault carrying the masked selector. They also check that stack faults and successes carry a zero error code, and that the outer flag never appears with a fault. The checks further down the order can only be shown by the bench's sweep. That includes which fault wins when several conditions fail, the conforming and non-conforming privilege rules, the exact-fit edge of the stack area with an immediate count, and each check on the stack selector. The sweep runs over every combination of levels, RPLs and DPLs, for each injected failure.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2,
    FLT_SS   = 2'd3
  } flt_e;

  typedef struct packed {
    logic        hit;
    flt_e        kind;
    logic [15:0] code;
  } verdict_t;

  localparam verdict_t VERDICT_PASS = '{hit: 1'b0, kind: FLT_NONE, code: 16'h0000};

  function automatic logic [15:0] sel_err(input logic [15:0] sel);
    return {sel[15:2], 2'b00};
  endfunction

  function automatic logic sel_null(input logic [15:0] sel);
    return (sel[15:2] == 14'd0);
  endfunction
endpackage

// File: rtl/frc_stack_fit.sv
module frc_stack_fit #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] limit,
  input  logic              op32,
  input  logic              outer,
  input  logic [IMM_W-1:0]  imm,
  output logic              fit
);
  localparam int W = ADDR_W + 1;

  logic [W-1:0] base_bytes;
  logic [W-1:0] need;
  logic [W-1:0] last;

  always_comb begin
    if (outer) base_bytes = op32 ? W'(16) : W'(8);
    else       base_bytes = op32 ? W'(8)  : W'(4);
    need = base_bytes + (outer ? W'(imm) : W'(0));
    last = {1'b0, ptr} + need - W'(1);
    fit  = (last <= {1'b0, limit});
  end
endmodule

// File: rtl/frc_code_desc_check.sv
module frc_code_desc_check
  import frc_pkg::*;
(
  input  logic [15:0] sel,
  input  logic [1:0]  tgt_lvl,
  input  logic        in_tbl,
  input  logic        is_code,
  input  logic        conf,
  input  logic [1:0]  dpl,
  input  logic        present,
  output verdict_t    verdict
);
  logic priv_ok;

  always_comb begin
    priv_ok = conf ? (dpl <= tgt_lvl) : (dpl == tgt_lvl);
    verdict = VERDICT_PASS;
    if (sel_null(sel)) begin
      verdict = '{hit: 1'b1, kind: FLT_GP, code: 16'h0000};
    end else if (!in_tbl || !is_code || !priv_ok) begin
      verdict = '{hit: 1'b1, kind: FLT_GP, code: sel_err(sel)};
    end else if (!present) begin
      verdict = '{hit: 1'b1, kind: FLT_NP, code: sel_err(sel)};
    end
  end
endmodule

// File: rtl/frc_stack_desc_check.sv
module frc_stack_desc_check
  import frc_pkg::*;
(
  input  logic [15:0] sel,
  input  logic [1:0]  code_rpl,
  input  logic        in_tbl,
  input  logic        wr_data,
  input  logic [1:0]  dpl,
  input  logic        present,
  output verdict_t    verdict
);
  always_comb begin
    verdict = VERDICT_PASS;
    if (sel_null(sel)) begin
      verdict = '{hit: 1'b1, kind: FLT_GP, code: 16'h0000};
    end else if (!in_tbl || (sel[1:0] != code_rpl) || !wr_data || (dpl != code_rpl)) begin
      verdict = '{hit: 1'b1, kind: FLT_GP, code: sel_err(sel)};
    end else if (!present) begin
      verdict = '{hit: 1'b1, kind: FLT_NP, code: sel_err(sel)};
    end
  end
endmodule

// File: rtl/frc_far_ret_check.sv
module frc_far_ret_check
  import frc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              op32,
  input  logic [1:0]        cpl,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] stk_ptr,
  input  logic [ADDR_W-1:0] stk_lim,
  input  logic [15:0]       cs_sel,
  input  logic              cs_in_tbl,
  input  logic              cs_is_code,
  input  logic              cs_conf,
  input  logic [1:0]        cs_dpl,
  input  logic              cs_present,
  input  logic [ADDR_W-1:0] cs_lim,
  input  logic [ADDR_W-1:0] ret_ofs,
  input  logic [15:0]       ss_sel,
  input  logic              ss_in_tbl,
  input  logic              ss_wr_data,
  input  logic [1:0]        ss_dpl,
  input  logic              ss_present,
  output logic              res_valid,
  output logic [1:0]        res_fault,
  output logic [15:0]       res_code,
  output logic              res_outer
);
  logic [1:0] rpl;
  logic       outer_path;
  logic [1:0] tgt_lvl;
  logic       pre_fit;
  logic       out_fit;
  verdict_t   code_v;
  verdict_t   stk_v;

  assign rpl        = cs_sel[1:0];
  assign outer_path = (rpl > cpl);
  assign tgt_lvl    = outer_path ? rpl : cpl;

  frc_stack_fit #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_pre_fit (
    .ptr(stk_ptr), .limit(stk_lim), .op32(op32), .outer(1'b0), .imm(imm), .fit(pre_fit)
  );

  frc_stack_fit #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_out_fit (
    .ptr(stk_ptr), .limit(stk_lim), .op32(op32), .outer(1'b1), .imm(imm), .fit(out_fit)
  );

  frc_code_desc_check u_code_chk (
    .sel(cs_sel), .tgt_lvl(tgt_lvl), .in_tbl(cs_in_tbl), .is_code(cs_is_code),
    .conf(cs_conf), .dpl(cs_dpl), .present(cs_present), .verdict(code_v)
  );

  frc_stack_desc_check u_stk_chk (
    .sel(ss_sel), .code_rpl(rpl), .in_tbl(ss_in_tbl), .wr_data(ss_wr_data),
    .dpl(ss_dpl), .present(ss_present), .verdict(stk_v)
  );

  // Priority selection of the first failing check
  flt_e        nxt_fault;
  logic [15:0] nxt_code;
  logic        nxt_outer;

  always_comb begin
    nxt_fault = FLT_NONE;
    nxt_code  = 16'h0000;
    nxt_outer = 1'b0;
    if (!pre_fit) begin
      nxt_fault = FLT_SS;
    end else if (rpl < cpl) begin
      nxt_fault = FLT_GP;
      nxt_code  = sel_err(cs_sel);
    end else if (outer_path && !out_fit) begin
      nxt_fault = FLT_SS;
    end else if (code_v.hit) begin
      nxt_fault = code_v.kind;
      nxt_code  = code_v.code;
    end else if (outer_path && stk_v.hit) begin
      nxt_fault = stk_v.kind;
      nxt_code  = stk_v.code;
    end else if (ret_ofs > cs_lim) begin
      nxt_fault = FLT_GP;
    end else begin
      nxt_outer = outer_path;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_fault <= 2'd0;
      res_code  <= 16'h0000;
      res_outer <= 1'b0;
    end else if (req_valid) begin
      res_fault <= nxt_fault;
      res_code  <= nxt_code;
      res_outer <= nxt_outer;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid); // R1
  AST_PRE_STACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pre_fit) |=> (res_fault == 2'd3 && res_code == 16'h0000)); // R2
  AST_RPL_LOW_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pre_fit && (cs_sel[1:0] < cpl)) |=>
      (res_fault == 2'd1 && res_code == {$past(cs_sel[15:2]), 2'b00})); // R3
  AST_OUTER_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_outer) |-> (res_fault == 2'd0)); // R4
  AST_SS_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault == 2'd3) |-> (res_code == 16'h0000)); // R9
  AST_PASS_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault == 2'd0) |-> (res_code == 16'h0000)); // R12
endmodule

// File: tb/frc_far_ret_check_tb_top.sv
module frc_far_ret_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int IMM_W  = 16;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              op32;
  logic [1:0]        cpl;
  logic [IMM_W-1:0]  imm;
  logic [ADDR_W-1:0] stk_ptr, stk_lim;
  logic [15:0]       cs_sel;
  logic              cs_in_tbl, cs_is_code, cs_conf, cs_present;
  logic [1:0]        cs_dpl;
  logic [ADDR_W-1:0] cs_lim, ret_ofs;
  logic [15:0]       ss_sel;
  logic              ss_in_tbl, ss_wr_data, ss_present;
  logic [1:0]        ss_dpl;
  logic              res_valid;
  logic [1:0]        res_fault;
  logic [15:0]       res_code;
  logic              res_outer;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  frc_far_ret_check #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op32(op32), .cpl(cpl), .imm(imm),
    .stk_ptr(stk_ptr), .stk_lim(stk_lim), .cs_sel(cs_sel), .cs_in_tbl(cs_in_tbl),
    .cs_is_code(cs_is_code), .cs_conf(cs_conf), .cs_dpl(cs_dpl), .cs_present(cs_present),
    .cs_lim(cs_lim), .ret_ofs(ret_ofs), .ss_sel(ss_sel), .ss_in_tbl(ss_in_tbl),
    .ss_wr_data(ss_wr_data), .ss_dpl(ss_dpl), .ss_present(ss_present),
    .res_valid(res_valid), .res_fault(res_fault), .res_code(res_code), .res_outer(res_outer)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected verdict from the requirements: {outer, fault, code}
  function automatic logic [18:0] expect_of();
    longint pre_need, out_need;
    logic [1:0] r;
    logic [1:0] tl;
    bit outer, cnull, snull, priv;
    r = cs_sel[1:0];
    pre_need = op32 ? 8 : 4;
    out_need = (op32 ? 16 : 8) + longint'(imm);
    outer = (r > cpl);
    tl = outer ? r : cpl;
    cnull = (cs_sel[15:2] == 0);
    snull = (ss_sel[15:2] == 0);
    priv = cs_conf ? (cs_dpl <= tl) : (cs_dpl == tl);
    if (longint'(stk_ptr) + pre_need - 1 > longint'(stk_lim)) return {1'b0, 2'd3, 16'h0};       // R2
    if (r < cpl) return {1'b0, 2'd1, cs_sel & 16'hFFFC};                                          // R3
    if (outer && (longint'(stk_ptr) + out_need - 1 > longint'(stk_lim))) return {1'b0, 2'd3, 16'h0}; // R9
    if (cnull) return {1'b0, 2'd1, 16'h0};                                                         // R5
    if (!cs_in_tbl || !cs_is_code) return {1'b0, 2'd1, cs_sel & 16'hFFFC};                         // R6
    if (!priv) return {1'b0, 2'd1, cs_sel & 16'hFFFC};                                             // R7
    if (!cs_present) return {1'b0, 2'd2, cs_sel & 16'hFFFC};                                       // R8
    if (outer) begin                                                                               // R10
      if (snull) return {1'b0, 2'd1, 16'h0};
      if (!ss_in_tbl || ss_sel[1:0] != r || !ss_wr_data || ss_dpl != r)
        return {1'b0, 2'd1, ss_sel & 16'hFFFC};
      if (!ss_present) return {1'b0, 2'd2, ss_sel & 16'hFFFC};
    end
    if (ret_ofs > cs_lim) return {1'b0, 2'd1, 16'h0};                                              // R11
    return {outer, 2'd0, 16'h0};                                                                   // R4 R12
  endfunction

  function automatic string tag_of(input int inj);
    case (inj)
      0:  return "R4_R12";
      1:  return "R2";
      2:  return "R5";
      3, 4: return "R6";
      5:  return "R8";
      6, 14: return "R9";
      7, 8, 9, 10, 11, 12: return "R10";
      13: return "R11";
      default: return "R7";
    endcase
  endfunction

  task automatic setup(input int c, input int r, input int cf, input int d, input int inj, input int o32);
    int need;
    op32 = o32[0];
    cpl = c[1:0];
    imm = IMM_W'((d * 4 + r) * 2);
    stk_lim = 32'h0000_FFFF;
    stk_ptr = 32'h0000_0100;
    cs_sel = {13'h0005, 1'b0, r[1:0]};
    cs_in_tbl = 1'b1; cs_is_code = 1'b1; cs_conf = cf[0]; cs_dpl = d[1:0]; cs_present = 1'b1;
    cs_lim = 32'h0000_1000; ret_ofs = 32'h0000_0020;
    ss_sel = {13'h0009, 1'b1, r[1:0]};
    ss_in_tbl = 1'b1; ss_wr_data = 1'b1; ss_dpl = r[1:0]; ss_present = 1'b1;
    need = (o32 != 0 ? 16 : 8) + int'(imm);
    case (inj)
      1:  stk_ptr = stk_lim - 32'(o32 != 0 ? 6 : 2);
      2:  cs_sel = {14'h0, r[1:0]};
      3:  cs_in_tbl = 1'b0;
      4:  cs_is_code = 1'b0;
      5:  cs_present = 1'b0;
      6:  stk_ptr = stk_lim - 32'(need) + 32'd2;
      7:  ss_sel = {14'h0, r[1:0]};
      8:  ss_in_tbl = 1'b0;
      9:  ss_sel = {13'h0009, 1'b1, r[1:0] + 2'd1};
      10: ss_wr_data = 1'b0;
      11: ss_dpl = r[1:0] + 2'd1;
      12: ss_present = 1'b0;
      13: ret_ofs = cs_lim + 32'd1;
      14: stk_ptr = stk_lim - 32'(need) + 32'd1;
      default: ;
    endcase
  endtask

  task automatic run_one(input string tag);
    logic [18:0] e;
    e = expect_of();
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid === 1'b1, "R1", longint'(res_valid), 1);
    check({res_outer, res_fault, res_code} === e, tag, longint'({res_outer, res_fault, res_code}), longint'(e));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    setup(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check({res_valid, res_fault, res_code, res_outer} === 20'h0, "R1", longint'({res_valid, res_fault, res_code, res_outer}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid === 1'b0, "R1", longint'(res_valid), 0);

    for (int o = 0; o < 2; o++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          for (int cf = 0; cf < 2; cf++)
            for (int d = 0; d < 4; d++)
              for (int inj = 0; inj < 15; inj++) begin
                setup(c, r, cf, d, inj, o);
                run_one((inj == 0 && !(cf != 0 ? d <= (r > c ? r : c) : d == (r > c ? r : c))) ? "R7" :
                        (r < c && inj != 1) ? "R3" : tag_of(inj));
              end

    // R1: idle cycle after last request
    @(negedge clk);
    check(res_valid === 1'b0, "R1", longint'(res_valid), 0);
    finish_run();
  end
endmodule